// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This unit takes one 32-bit instruction word together with its instruction address and two 64-bit operand values. It decides whether the word is a compare-and-trap instruction and, if so, whether that trap fires. Four encodings are recognised:

- word and doubleword register-register forms;
- word and doubleword forms that take a 16-bit immediate in place of the second operand.

A 5-bit condition mask picks any mix of five outcomes: signed less, signed greater, equal, unsigned less and unsigned greater. The trap fires when any selected outcome holds.

The result appears one clock after the input strobe. When the trap fires, the next program counter stays on the faulting instruction, the program-interrupt vector is presented and a trap status bit is raised. Otherwise the counter moves on by one instruction.

A pipeline stage instantiates the unit after its operand read. The register file, interrupt delivery and the return path all live elsewhere.

Top module: `trap_eval_unit`

## Requirements
- R1: Only four words are traps: bits 31..26 equal 31 with bits 10..1 equal 4 (word) or 68 (doubleword), or bits 31..26 equal 3 (immediate word) or 2 (immediate doubleword). Bit 0 is ignored. Any other word sets `illegal`, clears `trap_taken` and gives `next_pc` = `cia` + 4.
- R2: The mask is bits 25..21. Mask bit 4 selects signed a<b, bit 3 signed a>b, bit 2 a==b, bit 1 unsigned a<b and bit 0 unsigned a>b. The trap fires when any selected condition is true.
- R3: Word forms (opcode 31/XO 4 and opcode 3) compare only bits 31..0 of both operands. The upper 32 bits have no effect on the outcome.
- R4: Doubleword forms (opcode 31/XO 68 and opcode 2) compare all 64 bits.
- R5: Immediate forms use bits 15..0 of the word, sign-extended, as the second operand. `opnd_b` is ignored.
- R6: A mask of 0 never traps. A mask of 31 traps on every recognised form, for example on word 0x7FE00008.
- R7: On a taken trap, `next_pc` = `cia`, `vector` = 0x700 and `status_trap` = 1. Otherwise `vector` = 0 and `status_trap` = 0, and `next_pc` = `cia` + 4 modulo 2^64.
- R8: Outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Reset clears `out_valid`, `trap_taken`, `illegal` and `status_trap`.
- R9: Combined masks behave as follows:
  - 4 is equal and 24 is not-equal;
  - 12 is signed greater-or-equal and 20 is signed less-or-equal;
  - 5 is unsigned greater-or-equal and 6 is unsigned less-or-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| cia | input | 64 | Address of the instruction |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand (register forms) |
| out_valid | output | 1 | Result valid |
| trap_taken | output | 1 | Trap fires |
| illegal | output | 1 | Word is not a trap form |
| next_pc | output | 64 | Next program counter |
| vector | output | 64 | Exception vector, 0 when no trap |
| status_trap | output | 1 | Trap bit of saved machine status |

## Verification
The bench aims at the following corner cases:

- **Signed/unsigned split.** Operands such as low word 0xFFFFFFFF against 1 order differently as signed and as unsigned. Swapped mask bits would trap on the wrong side.
- **Word width.** Operands that match in the low half but differ above it show whether the word forms really drop the upper half. A unit that compares 64 bits would miss word-form equality traps.
- **Immediate sign.** An immediate of 0xFFFF must act as -1. Zero-extension would flip both the signed and the unsigned results.
- **Mask extremes and undecoded words.** The all-zero mask, the all-ones mask and undecoded words are each driven. This exposes a unit that traps unconditionally or advances the PC on a fault.
- **Address wrap.** An address at the top of the space checks that the +4 wraps.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned MASK_W  = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned WORD_W  = 32;

  localparam logic [5:0] OP_XFORM = 6'd31;
  localparam logic [5:0] OP_TWI   = 6'd3;
  localparam logic [5:0] OP_TDI   = 6'd2;
  localparam logic [9:0] XO_TW    = 10'd4;
  localparam logic [9:0] XO_TD    = 10'd68;

  localparam logic [15:0] PROG_VECTOR = 16'h0700;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_TW,
    FORM_TD,
    FORM_TWI,
    FORM_TDI
  } trap_form_e;

  // condition vector ordered so bit i has mask weight 2**i
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } cond_t;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [INSTR_W-1:0] instr,
  output trap_form_e         form,
  output logic [MASK_W-1:0]  mask,
  output logic               known,
  output logic               is_word,
  output logic               uses_imm,
  output logic [XLEN-1:0]    imm_ext
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [5:0] opcd;
  logic [9:0] xo;
  logic       unused_fields;

  assign opcd          = instr[31:26];
  assign xo            = instr[10:1];
  assign mask          = instr[25:21];
  assign unused_fields = ^{instr[20:16], instr[0]};

  always_comb begin
    form = FORM_NONE;
    if (opcd == OP_XFORM) begin
      if (xo == XO_TW)      form = FORM_TW;
      else if (xo == XO_TD) form = FORM_TD;
    end else if (opcd == OP_TWI) begin
      form = FORM_TWI;
    end else if (opcd == OP_TDI) begin
      form = FORM_TDI;
    end
  end

  assign known    = (form != FORM_NONE);
  assign is_word  = (form == FORM_TW) || (form == FORM_TWI);
  assign uses_imm = (form == FORM_TWI) || (form == FORM_TDI);
  assign imm_ext  = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            is_word,
  output cond_t           cond
);
  localparam int unsigned HI_W = XLEN - WORD_W;

  logic [XLEN-1:0] a_s, b_s, a_u, b_u;

  // narrow operands are widened so one comparator serves both widths
  always_comb begin
    if (is_word) begin
      a_s = {{HI_W{a[WORD_W-1]}}, a[WORD_W-1:0]};
      b_s = {{HI_W{b[WORD_W-1]}}, b[WORD_W-1:0]};
      a_u = {{HI_W{1'b0}}, a[WORD_W-1:0]};
      b_u = {{HI_W{1'b0}}, b[WORD_W-1:0]};
    end else begin
      a_s = a;
      b_s = b;
      a_u = a;
      b_u = b;
    end
  end

  assign cond.slt = $signed(a_s) < $signed(b_s);
  assign cond.sgt = $signed(b_s) < $signed(a_s);
  assign cond.eq  = (a_u == b_u);
  assign cond.ult = a_u < b_u;
  assign cond.ugt = b_u < a_u;
endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned STEP   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  cia,
  input  logic [XLEN-1:0]    opnd_a,
  input  logic [XLEN-1:0]    opnd_b,
  output logic               out_valid,
  output logic               trap_taken,
  output logic               illegal,
  output logic [ADDR_W-1:0]  next_pc,
  output logic [ADDR_W-1:0]  vector,
  output logic               status_trap
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(PROG_VECTOR);
  localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(STEP);

  trap_form_e        form;
  logic [MASK_W-1:0] mask;
  logic              known, is_word, uses_imm;
  logic [XLEN-1:0]   imm_ext, b_sel;
  cond_t             cond;

  logic              fire_d, illegal_d;
  logic [ADDR_W-1:0] next_pc_d, vector_d;

  trap_decode #(.XLEN(XLEN)) u_decode (
    .instr    (instr),
    .form     (form),
    .mask     (mask),
    .known    (known),
    .is_word  (is_word),
    .uses_imm (uses_imm),
    .imm_ext  (imm_ext)
  );

  assign b_sel = uses_imm ? imm_ext : opnd_b;

  trap_compare #(.XLEN(XLEN)) u_compare (
    .a       (opnd_a),
    .b       (b_sel),
    .is_word (is_word),
    .cond    (cond)
  );

  always_comb begin
    fire_d    = known && |(mask & cond);
    illegal_d = !known;
    next_pc_d = fire_d ? cia : cia + PC_STEP;
    vector_d  = fire_d ? VEC_ADDR : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_taken  <= 1'b0;
      illegal     <= 1'b0;
      status_trap <= 1'b0;
      next_pc     <= '0;
      vector      <= '0;
    end else if (in_valid) begin
      trap_taken  <= fire_d;
      illegal     <= illegal_d;
      status_trap <= fire_d;
      next_pc     <= next_pc_d;
      vector      <= vector_d;
    end
  end
endmodule

// File: rtl/trap_eval_checker.sv
module trap_eval_checker #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [ADDR_W-1:0] cia,
  input logic              out_valid,
  input logic              trap_taken,
  input logic              illegal,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] vector,
  input logic              status_trap
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_TAKEN_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!trap_taken || next_pc == $past(cia))); // R7
  AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (trap_taken || next_pc == $past(cia) + ADDR_W'(4))); // R7
  AST_TAKEN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && trap_taken) |-> (vector == ADDR_W'(16'h0700) && status_trap)); // R7
  AST_QUIET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trap_taken) |-> (vector == '0 && !status_trap)); // R7
  AST_ILLEGAL_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> !trap_taken); // R1
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[25:21] == 5'd0) |=> !trap_taken); // R6
  AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[25:21] == 5'd31 && instr[31:26] inside {6'd2, 6'd3}) |=> trap_taken); // R6
endmodule

bind trap_eval_unit trap_eval_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .instr       (instr),
  .cia         (cia),
  .out_valid   (out_valid),
  .trap_taken  (trap_taken),
  .illegal     (illegal),
  .next_pc     (next_pc),
  .vector      (vector),
  .status_trap (status_trap)
);

// File: tb/trap_eval_unit_bench.sv
`timescale 1ns/1ps
module trap_eval_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] cia, opnd_a, opnd_b;
  logic        out_valid, trap_taken, illegal, status_trap;
  logic [63:0] next_pc, vector;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trap_eval_unit u_trap_eval_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .cia(cia),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
    .trap_taken(trap_taken), .illegal(illegal), .next_pc(next_pc),
    .vector(vector), .status_trap(status_trap)
  );

  function automatic logic [31:0] enc_x(logic [4:0] to, logic [9:0] xo);
    return {6'd31, to, 5'd3, 5'd4, xo, 1'b0};
  endfunction

  function automatic logic [31:0] enc_d(logic [5:0] op, logic [4:0] to, logic [15:0] imm);
    return {op, to, 5'd7, imm};
  endfunction

  // reference model built straight from the requirement text
  function automatic void ref_model(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                                    output bit ill, output bit fire);
    logic [5:0] op = w[31:26];
    logic [4:0] to = w[25:21];
    logic [9:0] xo = w[10:1];
    bit recog, word, imm;
    logic [63:0] bv;
    bit lt, gt, eq, ltu, gtu;
    recog = (op == 6'd31 && (xo == 10'd4 || xo == 10'd68)) || op == 6'd3 || op == 6'd2;
    word  = (op == 6'd31 && xo == 10'd4) || op == 6'd3;
    imm   = (op == 6'd3) || (op == 6'd2);
    bv    = imm ? {{48{w[15]}}, w[15:0]} : b;
    if (word) begin
      int sa = int'(a[31:0]);
      int sb = int'(bv[31:0]);
      int unsigned ua = a[31:0];
      int unsigned ub = bv[31:0];
      lt = sa < sb; gt = sa > sb; eq = ua == ub; ltu = ua < ub; gtu = ua > ub;
    end else begin
      longint sa = longint'(a);
      longint sb = longint'(bv);
      longint unsigned ua = a;
      longint unsigned ub = bv;
      lt = sa < sb; gt = sa > sb; eq = ua == ub; ltu = ua < ub; gtu = ua > ub;
    end
    ill  = !recog;
    fire = recog && ((to[4] && lt) || (to[3] && gt) || (to[2] && eq) || (to[1] && ltu) || (to[0] && gtu));
  endfunction

  task automatic run_one(input logic [31:0] w, input logic [63:0] pc, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
    bit ill, fire;
    logic [130:0] exp_v, act_v;
    ref_model(w, a, b, ill, fire);
    @(negedge clk);
    in_valid = 1'b1; instr = w; cia = pc; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    exp_v = {1'b1, fire, ill, fire ? pc : pc + 64'd4, fire ? 64'h700 : 64'd0, fire};
    act_v = {out_valid, trap_taken, illegal, next_pc, vector, status_trap};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, act_v, exp_v);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp_b, input string tag);
    checks++;
    if (act !== exp_b) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp_b);
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; cia = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check_bit(out_valid, 1'b0, "R8 reset out_valid");
    check_bit(trap_taken | illegal | status_trap, 1'b0, "R8 reset flags");
    rst_n = 1'b1;
    @(negedge clk);

    run_one(32'h7FE00008, 64'h1000, 64'd5, 64'd9, "R6 full mask");
    run_one(32'h7C000008, 64'h1004, 64'd7, 64'd7, "R6 zero mask");
    run_one(enc_x(5'd4, 10'd4),  64'h2000, 64'h12340000_00000005, 64'h56780000_00000005, "R3 word ignores upper");
    run_one(enc_x(5'd4, 10'd68), 64'h2004, 64'h12340000_00000005, 64'h56780000_00000005, "R4 dword full compare");
    run_one(enc_x(5'd16, 10'd4), 64'h2008, 64'h00000000_FFFFFFFF, 64'd1, "R2 signed lt");
    run_one(enc_x(5'd2, 10'd4),  64'h200C, 64'h00000000_FFFFFFFF, 64'd1, "R2 unsigned lt");
    run_one(enc_x(5'd1, 10'd68), 64'h2010, 64'h80000000_00000000, 64'd1, "R4 unsigned gt");
    run_one(enc_d(6'd3, 5'd8, 16'hFFFF), 64'h3000, 64'd0, 64'd99, "R5 imm word signed gt");
    run_one(enc_d(6'd2, 5'd1, 16'hFFFF), 64'h3004, 64'd5, 64'd0, "R5 imm dword unsigned");
    run_one(enc_d(6'd2, 5'd4, 16'hFFFF), 64'h3008, 64'hFFFFFFFF_FFFFFFFF, 64'd3, "R5 imm equal");
    run_one(enc_d(6'd3, 5'd31, 16'h0000), 64'h300C, 64'd1, 64'd1, "R6 imm full mask");
    run_one(32'h7C000010, 64'h4000, 64'd1, 64'd1, "R1 bad xo");
    run_one(32'h38000000, 64'h4004, 64'd1, 64'd1, "R1 other opcode");
    run_one(32'h7FE00009, 64'h4008, 64'd1, 64'd2, "R1 record bit");
    run_one(enc_x(5'd0, 10'd4), 64'hFFFFFFFF_FFFFFFFC, 64'd1, 64'd2, "R7 pc wrap");
    run_one(enc_x(5'd24, 10'd4), 64'h5000, 64'd8, 64'd8, "R9 ne equal");
    run_one(enc_x(5'd24, 10'd4), 64'h5004, 64'd8, 64'd9, "R9 ne differ");
    run_one(enc_x(5'd12, 10'd4), 64'h5008, 64'd3, 64'hFFFFFFFF, "R9 sge");
    run_one(enc_x(5'd20, 10'd68), 64'h500C, 64'd3, 64'd3, "R9 sle");
    run_one(enc_x(5'd5, 10'd4), 64'h5010, 64'd2, 64'hFFFFFFFF, "R9 uge");
    run_one(enc_x(5'd6, 10'd68), 64'h5014, 64'd2, 64'd1, "R9 ule");
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R8 idle after strobe");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      int sel = $urandom_range(0, 4);
      logic [4:0] to = 5'($urandom_range(0, 31));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b[31:0] = a[31:0];
      if ($urandom_range(0, 7) == 0) b = a;
      case (sel)
        0: w = enc_x(to, 10'd4);
        1: w = enc_x(to, 10'd68);
        2: w = enc_d(6'd3, to, 16'($urandom));
        3: w = enc_d(6'd2, to, 16'($urandom));
        default: w = $urandom;
      endcase
      run_one(w, {$urandom, $urandom}, a, b, "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule